// File: doc/BRIEF.md
# Dual-channel UART interrupt register front-end

This block is the register face of a two-channel UART. Channel A serves as the console port and channel B as the auxiliary port. A processor reaches it through a simple single-cycle register bus. Each channel has a status register, a command register and a holding register, and the two channels share one interrupt status/mask register. Received bytes come in on a valid/ready byte stream for each channel. Transmitted bytes leave on another valid/ready stream for each channel. A single level interrupt request line goes to the processor.

Each channel's receive side keeps one byte. A byte that arrives while the buffer is full replaces the old byte and raises a sticky overrun flag. The transmit side collects written bytes in a small queue. The queue is released to the output stream only when the processor asks for a flush through the command register, or when the queue fills. A periodic tick input drives a divider. Every second tick it raises both transmit-ready interrupt bits, provided either transmit mask bit is set. Software uses this to keep draining its output buffers. Baud rate, framing, mode registers, the timer and the output port are outside this block. Writes to their offsets are accepted and have no effect.

A bus access is taken at the rising clock edge while `req_i` is high. Read data is combinational from the current state during the request cycle. Side effects of the read, such as clearing a bit, take hold at that edge.

Top module: `duart_irq_front`

## Requirements
- R1: Status registers sit at offset 0x0C (channel A) and 0x4C (channel B). Bit 0 is 1 when a received byte is waiting. Bit 2 always reads 1. Bit 4 is the overrun flag. All other bits read 0. After reset both read 0x04.
- R2: The interrupt register sits at offset 0x2C. A write loads the mask and a read returns the interrupt status. The bits are: bit 0 for A transmit ready, bit 1 for A receive ready, bit 4 for B transmit ready, bit 5 for B receive ready. After reset the status reads 0x00.
- R3: A byte accepted on a channel's receive stream sets bit 0 of that channel's status. It sets the channel's receive-ready interrupt bit and asserts `irq_o` only if the matching mask bit is already 1.
- R4: A read of a holding register (0x1C for A, 0x5C for B) returns the waiting byte. It also clears the channel's status bit 0 and its receive-ready interrupt bit. If no byte is waiting, the read returns 0x00 and the status stays unchanged.
- R5: A write to a holding register queues the byte for transmission. It also clears that channel's own transmit-ready interrupt bit.
- R6: Every second pulse of `tick_i` sets both transmit-ready interrupt bits (0 and 4) and asserts `irq_o`, if mask bit 0 or mask bit 4 is 1. Otherwise that pulse changes nothing.
- R7: Reading channel A's status deasserts `irq_o` in the following cycle, and the interrupt status is left as it was. Reading channel B's status leaves `irq_o` unchanged.
- R8: `irq_o` is a level. It rises only on a masked-in set event. It falls when channel A's status is read or when no interrupt status bit with its mask bit set remains. A set event in the same cycle as either of these keeps it high.
- R9: Transmit bytes leave in write order. The queue starts draining when a command register (0x14 for A, 0x54 for B) is written with bit 3 set, or when the queue becomes full. It then drains until empty. A holding write to a full queue is dropped. While `tx*_ready_i` is low, the valid byte stays unchanged.
- R10: A byte that arrives while the receive buffer is full replaces the old byte and sets the sticky overrun flag. A command register write with bit 4 set clears the flag.
- R11: Writes to any other offset, and writes to status registers, have no effect. Reads of any other offset return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid during the read cycle |
| tick_i | input | 1 | Periodic tick for the transmit-ready interrupt |
| rxa_valid_i | input | 1 | Channel A receive byte valid |
| rxa_data_i | input | DATA_W | Channel A receive byte |
| rxa_ready_o | output | 1 | Channel A receive ready (always 1) |
| rxb_valid_i | input | 1 | Channel B receive byte valid |
| rxb_data_i | input | DATA_W | Channel B receive byte |
| rxb_ready_o | output | 1 | Channel B receive ready (always 1) |
| txa_valid_o | output | 1 | Channel A transmit byte valid |
| txa_data_o | output | DATA_W | Channel A transmit byte |
| txa_ready_i | input | 1 | Channel A transmit sink ready |
| txb_valid_o | output | 1 | Channel B transmit byte valid |
| txb_data_o | output | DATA_W | Channel B transmit byte |
| txb_ready_i | input | 1 | Channel B transmit sink ready |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench delivers a byte while the receive mask is off, and checks that status bit 0 is set but no interrupt is raised. A design that ignored the mask would raise `irq_o` there. It reads channel B's status with an interrupt pending, then channel A's. It also drives a receive event and a channel A status read in the same cycle. A design that treated the two status reads alike, or gave the clear priority over the set, would show the wrong `irq_o` level. It sends single and double ticks, with and without transmit mask bits. It also reads an empty holding register. A divider that fired on every tick, or an empty read that disturbed status, would show up directly in the register values. On the transmit side, a scoreboard matches each output byte against the queued order. The bench confirms that nothing leaves before a flush. It also writes a fifth byte into a full, stalled queue, which a design that accepted it would emit as an extra byte.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned OFS_W  = 7;

  // per-channel register offsets, index 0 = channel A
  localparam logic [NUM_CH-1:0][OFS_W-1:0] OFS_STAT = {7'h4C, 7'h0C};
  localparam logic [NUM_CH-1:0][OFS_W-1:0] OFS_CMD  = {7'h54, 7'h14};
  localparam logic [NUM_CH-1:0][OFS_W-1:0] OFS_HOLD = {7'h5C, 7'h1C};
  localparam logic [OFS_W-1:0]             OFS_ISR  = 7'h2C;

  // status bit positions
  localparam int unsigned ST_RX_AVAIL = 0;
  localparam int unsigned ST_TX_RDY   = 2;
  localparam int unsigned ST_OVERRUN  = 4;

  // command bit positions
  localparam int unsigned CMD_FLUSH   = 3;
  localparam int unsigned CMD_CLR_OVR = 4;

  function automatic int unsigned tx_bit(int unsigned ch);
    return 4 * ch;
  endfunction

  function automatic int unsigned rx_bit(int unsigned ch);
    return 4 * ch + 1;
  endfunction

  typedef struct packed {
    logic hold_rd;
    logic hold_wr;
    logic cmd_wr;
  } ch_acc_t;
endpackage

// File: rtl/duart_decode.sv
module duart_decode
  import duart_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output ch_acc_t [NUM_CH-1:0] acc_o,
  output logic [NUM_CH-1:0] stat_rd_o,
  output logic              isr_rd_o,
  output logic              isr_wr_o
);
  logic rd, wr;
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      stat_rd_o[c]     = rd && (addr_i == ADDR_W'(OFS_STAT[c]));
      acc_o[c].hold_rd = rd && (addr_i == ADDR_W'(OFS_HOLD[c]));
      acc_o[c].hold_wr = wr && (addr_i == ADDR_W'(OFS_HOLD[c]));
      acc_o[c].cmd_wr  = wr && (addr_i == ADDR_W'(OFS_CMD[c]));
    end
    isr_rd_o = rd && (addr_i == ADDR_W'(OFS_ISR));
    isr_wr_o = wr && (addr_i == ADDR_W'(OFS_ISR));
  end
endmodule

// File: rtl/duart_chan.sv
module duart_chan
  import duart_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TX_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              hold_rd_i,
  input  logic              hold_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flush_i,
  input  logic              clr_ovr_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned PTR_W = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(TX_DEPTH + 1);

  // receive side
  logic              rx_full_q, ovr_q;
  logic [DATA_W-1:0] rx_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      ovr_q     <= 1'b0;
    end else begin
      if (rx_valid_i) begin
        rx_buf_q  <= rx_data_i;
        rx_full_q <= 1'b1;
      end else if (hold_rd_i) begin
        rx_full_q <= 1'b0;
      end
      if (rx_valid_i && rx_full_q && !hold_rd_i) ovr_q <= 1'b1;
      else if (clr_ovr_i)                         ovr_q <= 1'b0;
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[ST_RX_AVAIL] = rx_full_q;
    status_o[ST_TX_RDY]   = 1'b1;
    status_o[ST_OVERRUN]  = ovr_q;
  end
  assign rx_byte_o = rx_full_q ? rx_buf_q : '0;

  // transmit queue
  logic [DATA_W-1:0] mem_q [TX_DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              drain_q, drain_d, push, pop;

  assign push    = hold_wr_i && (cnt_q != CNT_W'(TX_DEPTH));
  assign pop     = tx_valid_o && tx_ready_i;
  assign cnt_nxt = cnt_q + CNT_W'(push) - CNT_W'(pop);

  always_comb begin
    drain_d = drain_q;
    if (flush_i || cnt_nxt == CNT_W'(TX_DEPTH)) drain_d = 1'b1;
    else if (cnt_nxt == '0)                     drain_d = 1'b0;
  end

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(TX_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      drain_q  <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q   <= cnt_nxt;
      drain_q <= drain_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign tx_valid_o = drain_q && (cnt_q != '0);
  assign tx_data_o  = mem_q[rd_ptr_q];

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_tx_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(flush_i || cnt_nxt == CNT_W'(TX_DEPTH)));

  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !clr_ovr_i |=> ovr_q);
endmodule

// File: rtl/duart_irq_ctrl.sv
module duart_irq_ctrl
  import duart_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              imr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] rx_evt_i,
  input  logic [NUM_CH-1:0] hold_rd_i,
  input  logic [NUM_CH-1:0] hold_wr_i,
  input  logic              stat_a_rd_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] isr_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DATA_W-1:0] isr_q, imr_q, isr_d, imr_d, set_v, clr_v, tx_mask;
  logic [CNT_W-1:0]  tick_cnt_q;
  logic              fire, set_evt, irq_q, irq_d;

  assign fire = tick_i && (tick_cnt_q == CNT_W'(TICK_DIV - 1));

  always_comb begin
    tx_mask = '0;
    set_v   = '0;
    clr_v   = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      tx_mask[tx_bit(c)] = 1'b1;
      if (rx_evt_i[c] && imr_q[rx_bit(c)]) set_v[rx_bit(c)] = 1'b1;
      if (hold_rd_i[c]) clr_v[rx_bit(c)] = 1'b1;
      if (hold_wr_i[c]) clr_v[tx_bit(c)] = 1'b1;
    end
    if (fire && |(imr_q & tx_mask)) set_v = set_v | tx_mask;
  end

  assign imr_d   = imr_wr_i ? wdata_i : imr_q;
  assign isr_d   = (isr_q & ~clr_v) | set_v;
  assign set_evt = |set_v;

  always_comb begin
    irq_d = irq_q;
    if (set_evt)                  irq_d = 1'b1;
    else if (stat_a_rd_i)         irq_d = 1'b0;
    else if ((isr_d & imr_d) == '0) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q      <= '0;
      imr_q      <= '0;
      irq_q      <= 1'b0;
      tick_cnt_q <= '0;
    end else begin
      isr_q <= isr_d;
      imr_q <= imr_d;
      irq_q <= irq_d;
      if (tick_i) tick_cnt_q <= fire ? '0 : tick_cnt_q + 1'b1;
    end
  end

  assign isr_o = isr_q;
  assign irq_o = irq_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam int unsigned RXB = rx_bit(g);
    localparam int unsigned TXB = tx_bit(g);
    p_rx_needs_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(isr_q[RXB]) |-> $past(imr_q[RXB]));
    p_tx_needs_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(isr_q[TXB]) |-> $past(|(imr_q & tx_mask)));
  end

  p_fire_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !fire);

  p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_a_rd_i && !set_evt |=> !irq_o);

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_evt));
endmodule

// File: rtl/duart_irq_front.sv
module duart_irq_front
  import duart_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TX_DEPTH = 4,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              rxa_valid_i,
  input  logic [DATA_W-1:0] rxa_data_i,
  output logic              rxa_ready_o,
  input  logic              rxb_valid_i,
  input  logic [DATA_W-1:0] rxb_data_i,
  output logic              rxb_ready_o,
  output logic              txa_valid_o,
  output logic [DATA_W-1:0] txa_data_o,
  input  logic              txa_ready_i,
  output logic              txb_valid_o,
  output logic [DATA_W-1:0] txb_data_o,
  input  logic              txb_ready_i,
  output logic              irq_o
);
  ch_acc_t [NUM_CH-1:0]             acc;
  logic [NUM_CH-1:0]                stat_rd, rx_valid, tx_ready, tx_valid;
  logic [NUM_CH-1:0]                hold_rd, hold_wr;
  logic [NUM_CH-1:0][DATA_W-1:0]    rx_data, tx_data, status, rx_byte;
  logic                             isr_rd, isr_wr;
  logic [DATA_W-1:0]                isr;

  assign rx_valid    = {rxb_valid_i, rxa_valid_i};
  assign rx_data     = {rxb_data_i, rxa_data_i};
  assign tx_ready    = {txb_ready_i, txa_ready_i};
  assign rxa_ready_o = 1'b1;
  assign rxb_ready_o = 1'b1;
  assign txa_valid_o = tx_valid[0];
  assign txb_valid_o = tx_valid[1];
  assign txa_data_o  = tx_data[0];
  assign txb_data_o  = tx_data[1];

  duart_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .acc_o    (acc),
    .stat_rd_o(stat_rd),
    .isr_rd_o (isr_rd),
    .isr_wr_o (isr_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hold_rd[c] = acc[c].hold_rd;
    assign hold_wr[c] = acc[c].hold_wr;
    duart_chan #(.DATA_W(DATA_W), .TX_DEPTH(TX_DEPTH)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rx_valid_i(rx_valid[c]),
      .rx_data_i (rx_data[c]),
      .hold_rd_i (acc[c].hold_rd),
      .hold_wr_i (acc[c].hold_wr),
      .wdata_i   (wdata_i),
      .flush_i   (acc[c].cmd_wr && wdata_i[CMD_FLUSH]),
      .clr_ovr_i (acc[c].cmd_wr && wdata_i[CMD_CLR_OVR]),
      .tx_ready_i(tx_ready[c]),
      .tx_valid_o(tx_valid[c]),
      .tx_data_o (tx_data[c]),
      .status_o  (status[c]),
      .rx_byte_o (rx_byte[c])
    );
  end

  duart_irq_ctrl #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .imr_wr_i   (isr_wr),
    .wdata_i    (wdata_i),
    .rx_evt_i   (rx_valid),
    .hold_rd_i  (hold_rd),
    .hold_wr_i  (hold_wr),
    .stat_a_rd_i(stat_rd[0]),
    .tick_i     (tick_i),
    .isr_o      (isr),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (stat_rd[c]) rdata_o = status[c];
      if (hold_rd[c]) rdata_o = rx_byte[c];
    end
    if (isr_rd) rdata_o = isr;
  end

  p_rdata_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> rdata_o == '0);
endmodule

// File: tb/duart_irq_front_tb_top.sv
module duart_irq_front_tb_top;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       rxa_v = 1'b0, rxb_v = 1'b0, rxa_r, rxb_r;
  logic [7:0] rxa_d = '0, rxb_d = '0, txa_d, txb_d;
  logic       txa_v, txb_v, txa_r = 1'b1, txb_r = 1'b1, irq;

  int errors = 0, checks = 0, na_seen = 0, nb_seen = 0;
  logic [7:0] qa[$], qb[$];
  logic [7:0] v;

  always #10 clk = ~clk;

  duart_irq_front dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .rxa_valid_i(rxa_v), .rxa_data_i(rxa_d), .rxa_ready_o(rxa_r),
    .rxb_valid_i(rxb_v), .rxb_data_i(rxb_d), .rxb_ready_o(rxb_r),
    .txa_valid_o(txa_v), .txa_data_o(txa_d), .txa_ready_i(txa_r),
    .txb_valid_o(txb_v), .txb_data_o(txb_d), .txb_ready_i(txb_r),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // driver: holding write also pushes the expected transmit byte
  task automatic send_tx(input int ch, input logic [7:0] d, input bit expect_kept);
    wr(ch == 0 ? 8'h1C : 8'h5C, d);
    if (expect_kept) begin
      if (ch == 0) qa.push_back(d); else qb.push_back(d);
    end
  endtask

  task automatic rx_byte(input int ch, input logic [7:0] d);
    @(negedge clk);
    if (ch == 0) begin rxa_v = 1'b1; rxa_d = d; end
    else begin rxb_v = 1'b1; rxb_d = d; end
    @(posedge clk); #1;
    rxa_v = 1'b0; rxb_v = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1; tick = 1'b0;
  endtask

  // monitor: compares each transmitted byte with the scoreboard
  always @(posedge clk) begin
    if (rst_ni && txa_v && txa_r) begin
      na_seen++;
      if (qa.size() == 0) chk(1'b0, "R9 txa extra byte", txa_d, 0);
      else chk_eq("R9 txa order", txa_d, qa.pop_front());
    end
    if (rst_ni && txb_v && txb_r) begin
      nb_seen++;
      if (qb.size() == 0) chk(1'b0, "R9 txb extra byte", txb_d, 0);
      else chk_eq("R9 txb order", txb_d, qb.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 / R2 reset state
    chk_eq("R8 irq after reset", irq, 0);
    rd(8'h0C, v); chk_eq("R1 status A reset", v, 8'h04);
    rd(8'h4C, v); chk_eq("R1 status B reset", v, 8'h04);
    rd(8'h2C, v); chk_eq("R2 isr reset", v, 8'h00);
    chk_eq("R9 txa idle after reset", txa_v, 0);

    // R3 byte with mask off
    rx_byte(0, 8'hA1);
    rd(8'h0C, v); chk_eq("R3 status A avail", v, 8'h05);
    rd(8'h2C, v); chk_eq("R3 isr unmasked", v, 8'h00);
    chk_eq("R3 irq unmasked", irq, 0);

    // R3 / R7 / R8 channel B with mask
    wr(8'h2C, 8'h22);
    rx_byte(1, 8'h5A);
    chk_eq("R3 irq on B rx", irq, 1);
    rd(8'h2C, v); chk_eq("R2 isr B rx bit5", v, 8'h20);
    rd(8'h4C, v); chk_eq("R1 status B avail", v, 8'h05);
    chk_eq("R7 status B read keeps irq", irq, 1);
    rd(8'h5C, v); chk_eq("R4 hold B data", v, 8'h5A);
    chk_eq("R8 irq drops when no enabled bit", irq, 0);
    rd(8'h4C, v); chk_eq("R4 status B cleared", v, 8'h04);

    // R4 holding A read and empty read
    rd(8'h1C, v); chk_eq("R4 hold A data", v, 8'hA1);
    rd(8'h1C, v); chk_eq("R4 empty hold read", v, 8'h00);
    rd(8'h0C, v); chk_eq("R4 empty read status", v, 8'h04);

    // R7 status A read drops irq, isr kept
    rx_byte(0, 8'h77);
    chk_eq("R3 irq on A rx", irq, 1);
    rd(8'h0C, v); chk_eq("R1 status A avail", v, 8'h05);
    chk_eq("R7 status A read drops irq", irq, 0);
    rd(8'h2C, v); chk_eq("R7 isr kept after status read", v, 8'h02);

    // R10 overrun
    rx_byte(0, 8'h22);
    rd(8'h0C, v); chk_eq("R10 overrun flag", v, 8'h15);
    rd(8'h1C, v); chk_eq("R10 newest byte kept", v, 8'h22);
    rd(8'h0C, v); chk_eq("R10 overrun sticky", v, 8'h14);
    wr(8'h14, 8'h10);
    rd(8'h0C, v); chk_eq("R10 overrun cleared", v, 8'h04);

    // R6 tick divider
    wr(8'h2C, 8'h01);
    do_tick();
    rd(8'h2C, v); chk_eq("R6 first tick no set", v, 8'h00);
    chk_eq("R6 first tick no irq", irq, 0);
    do_tick();
    chk_eq("R6 second tick irq", irq, 1);
    rd(8'h2C, v); chk_eq("R6 both tx bits", v, 8'h11);
    send_tx(0, 8'h41, 1'b1);
    rd(8'h2C, v); chk_eq("R5 hold A write clears bit0", v, 8'h10);
    chk_eq("R8 irq drops after clear", irq, 0);
    wr(8'h2C, 8'h00);
    do_tick(); do_tick();
    rd(8'h2C, v); chk_eq("R6 masked ticks no change", v, 8'h10);
    chk_eq("R6 masked ticks no irq", irq, 0);

    // R9 flush on command
    chk_eq("R9 txa held before flush", txa_v, 0);
    send_tx(0, 8'h42, 1'b1);
    chk_eq("R9 txa still held", txa_v, 0);
    wr(8'h14, 8'h08);
    repeat (6) @(posedge clk); #1;
    chk_eq("R9 txa drained", na_seen, 2);
    chk_eq("R9 txa idle after drain", txa_v, 0);

    // R9 fill-triggered drain, stall, drop on full
    @(negedge clk) txb_r = 1'b0;
    send_tx(1, 8'h61, 1'b1);
    rd(8'h2C, v); chk_eq("R5 hold B write clears bit4", v, 8'h00);
    send_tx(1, 8'h62, 1'b1);
    send_tx(1, 8'h63, 1'b1);
    chk_eq("R9 txb held before full", txb_v, 0);
    send_tx(1, 8'h64, 1'b1);
    chk_eq("R9 txb drains when full", txb_v, 1);
    chk_eq("R9 txb first byte", txb_d, 8'h61);
    send_tx(1, 8'h99, 1'b0);
    @(negedge clk) txb_r = 1'b1;
    repeat (8) @(posedge clk); #1;
    chk_eq("R9 txb drained four", nb_seen, 4);
    chk_eq("R9 txb scoreboard empty", qb.size(), 0);

    // R11 ignored writes and unmapped reads
    wr(8'h04, 8'hFF);
    wr(8'h0C, 8'hFF);
    wr(8'h24, 8'hFF);
    rd(8'h04, v); chk_eq("R11 unmapped read", v, 8'h00);
    rd(8'h0C, v); chk_eq("R11 status after ignored writes", v, 8'h04);
    rd(8'h2C, v); chk_eq("R11 isr after ignored writes", v, 8'h00);
    chk_eq("R11 txa untouched", txa_v, 0);

    // R8 set event wins over status A read
    wr(8'h2C, 8'h02);
    rx_byte(0, 8'h33);
    chk_eq("R3 irq set again", irq, 1);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h0C; rxa_v = 1'b1; rxa_d = 8'h44;
    @(posedge clk); #1;
    req = 1'b0; rxa_v = 1'b0;
    chk_eq("R8 set wins over status read", irq, 1);
    rd(8'h0C, v); chk_eq("R10 overrun on same-cycle byte", v, 8'h15);
    chk_eq("R7 later status read drops irq", irq, 0);
    rd(8'h1C, v); chk_eq("R4 hold A newest", v, 8'h44);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule